// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter Control

This block sends bytes on an asynchronous serial line. It has two stages. One is a one-byte holding register that software writes. The other is a shift stage that drives the line. Two flags tell software where the transmitter stands. The empty flag means the holding register can take another byte. The done flag means the line is idle and no frame is running. The block raises a one-cycle interrupt pulse each time a frame starts and the holding register frees up. It holds an interrupt level once the last queued frame has gone out.

Software sets three control bits with one control write: transmitter enable, start-pulse interrupt enable and done-level interrupt enable. A data write while the line is idle starts a frame on the next clock. A data write while a frame is running parks the byte, and that byte goes out directly after the running frame. The bit period comes from an outside baud generator as a count of clock cycles per bit. A parity enable and a two-stop-bit select fix the frame layout.

Top module: `serial_tx_ctl`

## Requirements
- R1: After reset the status byte reads 0x84 (bit 7 = empty flag, bit 2 = done flag, other bits zero), the line is high and both interrupts are low.
- R2: A data write while the transmitter is disabled starts no frame and leaves the status byte and the line unchanged.
- R3: A data write while enabled and idle starts a frame on the next clock: the done flag clears, the empty flag is set, the done interrupt drops and the line goes low for the start bit.
- R4: A frame start raises the start interrupt for exactly one cycle when the start interrupt enable is set, and raises it not at all when that enable is clear.
- R5: A data write while a frame is running clears only the empty flag, and the parked byte starts on the clock where the running frame ends, with no idle bit between the two frames.
- R6: When a frame ends and no byte is parked, the done flag sets and the done interrupt goes high only if the done interrupt enable is set.
- R7: A control write that turns the transmitter on from off sets both flags (status 0x84) and pulses the start interrupt if the new start interrupt enable is set.
- R8: A control write that turns the transmitter off from on aborts any frame: the status becomes 0x04 and the line stays high.
- R9: A control write with the done interrupt enable clear drops the done interrupt on the next clock.
- R10: A frame is a low start bit, 8 data bits LSB first, an even parity bit when parity is enabled, and one or two high stop bits. Each bit lasts `bit_cycles` clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_data | input | 1 | One-cycle data write strobe |
| wdata | input | 8 | Byte written on a data write |
| wr_ctrl | input | 1 | One-cycle control write strobe |
| ctrl_en | input | 1 | Transmitter enable value of a control write |
| ctrl_tie | input | 1 | Start interrupt enable value of a control write |
| ctrl_teie | input | 1 | Done interrupt enable value of a control write |
| par_en | input | 1 | Insert even parity bit |
| two_stop | input | 1 | Send two stop bits instead of one |
| bit_cycles | input | CW | Clock cycles per bit from the baud generator (at least 1) |
| tx | output | 1 | Serial line, idles high |
| status | output | 8 | Bit 7 empty flag, bit 2 done flag |
| txi | output | 1 | Start interrupt, one-cycle pulse |
| tei | output | 1 | Done interrupt, level |

## Verification
The hardest state to reach is a byte parked in the holding register at the moment the running frame ends. The bench must hit the exact frame-end clock to see the second start bit directly after the first frame's last stop bit. It writes the second byte one clock after the first. Then it counts edges from the first start to the predicted boundary and samples the line and the flags on both sides of that boundary. The same parked state is then reused: the bench disables the transmitter mid-frame to show the parked byte is dropped.

// File: rtl/serial_tx_ctl.sv
module serial_tx_ctl #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_data,
  input  logic [7:0]    wdata,
  input  logic          wr_ctrl,
  input  logic          ctrl_en,
  input  logic          ctrl_tie,
  input  logic          ctrl_teie,
  input  logic          par_en,
  input  logic          two_stop,
  input  logic [CW-1:0] bit_cycles,
  output logic          tx,
  output logic [7:0]    status,
  output logic          txi,
  output logic          tei
);
  logic          ten, tie, teie, tdre, tend;
  logic [7:0]    tdr;
  logic [11:0]   frame;
  logic [CW-1:0] cyc;
  logic [3:0]    bidx, nbits;
  logic          bit_last, frame_end, wr_go;

  function automatic logic [11:0] build(input logic [7:0] d, input logic p);
    return p ? {2'b11, ^d, d, 1'b0} : {3'b111, d, 1'b0};
  endfunction

  assign nbits     = 4'd10 + 4'(par_en) + 4'(two_stop);
  assign bit_last  = ({1'b0, cyc} + (CW+1)'(1)) >= {1'b0, bit_cycles};
  assign frame_end = !tend && bit_last && (bidx == nbits - 4'd1);
  assign wr_go     = wr_data && ten;
  assign tx        = tend ? 1'b1 : frame[0];
  assign status    = {tdre, 4'b0000, tend, 2'b00};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ten   <= 1'b0;
      tie   <= 1'b0;
      teie  <= 1'b0;
      tdre  <= 1'b1;
      tend  <= 1'b1;
      tdr   <= '0;
      frame <= '1;
      cyc   <= '0;
      bidx  <= '0;
      txi   <= 1'b0;
      tei   <= 1'b0;
    end else begin
      txi <= 1'b0;
      if (!tend) begin
        if (bit_last) begin
          cyc   <= '0;
          bidx  <= bidx + 4'd1;
          frame <= {1'b1, frame[11:1]};
        end else begin
          cyc <= cyc + CW'(1);
        end
      end

      if (frame_end) begin
        if (!tdre || wr_go) begin
          frame <= build(!tdre ? tdr : wdata, par_en);
          cyc   <= '0;
          bidx  <= '0;
          tdre  <= 1'b1;
          txi   <= tie;
          if (!tdre && wr_go) begin
            tdr  <= wdata;
            tdre <= 1'b0;
          end
        end else begin
          tend <= 1'b1;
          if (teie) tei <= 1'b1;
        end
      end else if (wr_go && tend) begin
        frame <= build(wdata, par_en);
        cyc   <= '0;
        bidx  <= '0;
        tend  <= 1'b0;
        tdre  <= 1'b1;
        tei   <= 1'b0;
        txi   <= tie;
      end else if (wr_go) begin
        tdr  <= wdata;
        tdre <= 1'b0;
      end

      if (wr_ctrl) begin
        ten  <= ctrl_en;
        tie  <= ctrl_tie;
        teie <= ctrl_teie;
        if (ctrl_en && !ten) begin
          tdre <= 1'b1;
          tend <= 1'b1;
          txi  <= ctrl_tie;
        end
        if (!ctrl_en && ten) begin
          tdre <= 1'b0;
          tend <= 1'b1;
          txi  <= 1'b0;
        end
        if (!ctrl_teie) tei <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/serial_tx_ctl_chk.sv
module serial_tx_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_data,
  input logic       wr_ctrl,
  input logic       ctrl_en,
  input logic       ctrl_teie,
  input logic       tx,
  input logic [7:0] status,
  input logic       txi,
  input logic       tei,
  input logic       ten,
  input logic       frame_end
);
  p_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && !ten && !wr_ctrl) |=> ($stable(status) && tx));

  p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && ten && status[2] && !wr_ctrl) |=> (status == 8'h80 && !tei && !tx));

  p_pulse_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    txi |-> status[7]);

  p_queue_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && ten && !status[2] && !wr_ctrl && !frame_end) |=> !status[7]);

  p_done_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tei) |-> status[2]);

  p_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && ctrl_en && !ten) |=> status == 8'h84);

  p_disable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !ctrl_en && ten) |=> (status == 8'h04 && tx && !txi));

  p_teie_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !ctrl_teie) |=> !tei);
endmodule

bind serial_tx_ctl serial_tx_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_ctrl(wr_ctrl),
  .ctrl_en(ctrl_en), .ctrl_teie(ctrl_teie), .tx(tx), .status(status),
  .txi(txi), .tei(tei), .ten(ten), .frame_end(frame_end)
);

// File: tb/test_serial_tx_ctl.sv
module test_serial_tx_ctl;
  localparam int B = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_data = 1'b0, wr_ctrl = 1'b0;
  logic [7:0] wdata = '0;
  logic ctrl_en = 1'b0, ctrl_tie = 1'b0, ctrl_teie = 1'b0;
  logic par_en = 1'b0, two_stop = 1'b0;
  logic [15:0] bit_cycles = 16'(B);
  logic tx, txi, tei;
  logic [7:0] status;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  serial_tx_ctl i_serial_tx_ctl (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wdata(wdata),
    .wr_ctrl(wr_ctrl), .ctrl_en(ctrl_en), .ctrl_tie(ctrl_tie),
    .ctrl_teie(ctrl_teie), .par_en(par_en), .two_stop(two_stop),
    .bit_cycles(bit_cycles), .tx(tx), .status(status), .txi(txi), .tei(tei)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_data = 1'b1; wdata = d;
    @(posedge clk); #1 wr_data = 1'b0;
  endtask

  task automatic ctl(input logic en, input logic ie, input logic ee);
    @(negedge clk); wr_ctrl = 1'b1; ctrl_en = en; ctrl_tie = ie; ctrl_teie = ee;
    @(posedge clk); #1 wr_ctrl = 1'b0;
  endtask

  task automatic check_frame(input logic [7:0] d, input logic p, input logic s2);
    int n = 10 + int'(p) + int'(s2);
    int cur = 0;
    for (int i = 0; i < n; i++) begin
      int tgt = i * B + 1;
      logic e;
      if (i == 0) e = 1'b0;
      else if (i <= 8) e = d[i-1];
      else if (i == 9 && p) e = ^d;
      else e = 1'b1;
      repeat (tgt - cur) @(posedge clk);
      cur = tgt;
      @(negedge clk);
      chk($sformatf("R10 bit%0d", i), int'(tx), int'(e));
    end
    repeat (n * B - cur) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 status", status, 8'h84);
    chk("R1 tx", tx, 1);
    chk("R1 txi", txi, 0);
    chk("R1 tei", tei, 0);
  endtask

  task automatic t_ignored;
    int lows = 0;
    wr(8'hFF);
    @(negedge clk);
    chk("R2 status", status, 8'h84);
    repeat (20) begin @(negedge clk); if (!tx) lows++; end
    chk("R2 line", lows, 0);
  endtask

  task automatic t_enable;
    ctl(1'b1, 1'b1, 1'b1);
    @(negedge clk);
    chk("R7 status", status, 8'h84);
    chk("R7 txi", txi, 1);
    @(negedge clk);
    chk("R4 one cycle", txi, 0);
  endtask

  task automatic t_single;
    wr(8'hA5);
    @(negedge clk);
    chk("R3 status", status, 8'h80);
    chk("R3 tei", tei, 0);
    chk("R3 tx", tx, 0);
    chk("R4 txi", txi, 1);
    check_frame(8'hA5, 1'b0, 1'b0);
    chk("R6 status", status, 8'h84);
    chk("R6 tei", tei, 1);
  endtask

  task automatic t_queue;
    par_en = 1'b1; two_stop = 1'b1;
    wr(8'h3C);
    chk("R3 tei drop", tei, 0);
    wr(8'h81);
    @(negedge clk);
    chk("R5 status", status, 8'h00);
    repeat (46) @(posedge clk);
    @(negedge clk);
    chk("R5 last stop", tx, 1);
    chk("R5 busy", status[2], 0);
    @(posedge clk);
    @(negedge clk);
    chk("R5 next status", status, 8'h80);
    chk("R5 next txi", txi, 1);
    chk("R5 next start", tx, 0);
    check_frame(8'h81, 1'b1, 1'b1);
    chk("R6 status q", status, 8'h84);
    chk("R6 tei q", tei, 1);
    par_en = 1'b0; two_stop = 1'b0;
  endtask

  task automatic t_teie_off;
    ctl(1'b1, 1'b1, 1'b0);
    @(negedge clk);
    chk("R9 tei", tei, 0);
    chk("R7 no pulse", txi, 0);
    chk("R9 status", status, 8'h84);
  endtask

  task automatic t_tei_masked;
    two_stop = 1'b1;
    wr(8'h5A);
    check_frame(8'h5A, 1'b0, 1'b1);
    chk("R6 masked status", status, 8'h84);
    chk("R6 masked tei", tei, 0);
    two_stop = 1'b0;
  endtask

  task automatic t_tie_off;
    ctl(1'b1, 1'b0, 1'b0);
    @(negedge clk);
    chk("R4 ctl", txi, 0);
    wr(8'h0F);
    @(negedge clk);
    chk("R4 off", txi, 0);
    chk("R3 status", status, 8'h80);
    check_frame(8'h0F, 1'b0, 1'b0);
  endtask

  task automatic t_disable;
    int lows = 0;
    ctl(1'b1, 1'b1, 1'b1);
    wr(8'hC3);
    wr(8'h11);
    @(negedge clk);
    chk("R5 parked", status, 8'h00);
    ctl(1'b0, 1'b1, 1'b1);
    @(negedge clk);
    chk("R8 status", status, 8'h04);
    chk("R8 tx", tx, 1);
    chk("R8 txi", txi, 0);
    repeat (60) begin @(negedge clk); if (!tx) lows++; end
    chk("R8 line", lows, 0);
    chk("R8 hold", status, 8'h04);
    wr(8'h77);
    @(negedge clk);
    chk("R2 off status", status, 8'h04);
    chk("R2 off tx", tx, 1);
    ctl(1'b1, 1'b0, 1'b1);
    @(negedge clk);
    chk("R7 re-enable", status, 8'h84);
    chk("R7 no tie", txi, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset;
    t_ignored;
    t_enable;
    t_single;
    t_queue;
    t_teie_off;
    t_tei_masked;
    t_tie_off;
    t_disable;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R10 watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule